// File: doc/BRIEF.md
# ECC Page Layout Stream Interleaver

This block sits between a page buffer engine on the host side and a raw flash byte channel. The host side sees a page as two streams: the user data bytes and a separate spare-area (OOB) stream. On the flash side each ECC step is stored in one piece: its data bytes, then two free user bytes, then that step's parity bytes. When writing, the block merges the host data and OOB streams into this raw order. When reading, it splits a raw byte stream back into a data stream and an OOB stream. Every stream is a byte-wide valid/ready channel with a last flag.

A transfer starts with a one-cycle start pulse. At that pulse the block captures the direction, whether an OOB stream is supplied, the step size in bytes and the number of steps. The parity length per step is derived from the step size at the fixed correction strength. In the OOB view, section i holds the two user bytes at offsets i×(2+parity) and i×(2+parity)+1, and the parity follows them. Bytes pass straight through without storage. A one-cycle done pulse marks the end of the page. A one-cycle error pulse marks a stream that signalled its end too early.

Top module: `nfc_layout_interleave`

## Requirements
- R1: The parity length per step is 14 bytes for a 512-byte step at strength 8. For any other step it is ceil(STRENGTH × bitlength(step_bytes × 8) / 8), rounded up to an even number. A page carries step_num × (step_bytes + 2 + parity) raw bytes, and its OOB stream carries step_num × (2 + parity) bytes.
- R2: In write mode with the OOB stream enabled, the raw output for each step in turn is: step_bytes host data bytes, then the next 2 + parity OOB stream bytes.
- R3: In write mode with the OOB stream disabled, every user and parity position of the raw output is 0xFF and ho_ready_o stays 0.
- R4: In read mode, raw data positions go to the rd_* output in order and raw user and parity positions go to the ro_* output in order. The two outputs are never valid together.
- R5: fo_last_o is high on the final raw byte of the page. rd_last_o is high on the final data byte. ro_last_o is high on the final OOB byte.
- R6: done_o pulses for exactly one cycle, in the cycle after the final byte of the last step is transferred, and busy_o falls in that same cycle.
- R7: If a host data byte, host OOB byte or raw input byte is accepted with its last flag set before the final byte of that stream, err_o pulses for one cycle in the next cycle, no done pulse follows, and the block returns to idle ready for a new start.
- R8: Under arbitrary valid/ready stalls no byte is lost or repeated. The channels of the direction not in use keep valid and ready low. When idle, every valid and ready output is low.
- R9: start_i and the configuration inputs are captured only while idle. A start pulse or a configuration change during a transfer has no effect on it.
- R10: After reset busy_o, done_o, err_o and all valid and ready outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a page transfer when idle |
| rd_mode_i | input | 1 | 1 = split raw into host streams, 0 = merge host streams into raw |
| oob_en_i | input | 1 | Write mode: host OOB stream supplied |
| step_bytes_i | input | STEP_W | Data bytes per ECC step |
| step_num_i | input | NUM_W | ECC steps per page |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at page end |
| err_o | output | 1 | One-cycle pulse on an early last flag |
| hd_valid_i | input | 1 | Host data in valid (write) |
| hd_data_i | input | 8 | Host data in byte |
| hd_last_i | input | 1 | Host data in last byte |
| hd_ready_o | output | 1 | Host data in ready |
| ho_valid_i | input | 1 | Host OOB in valid (write) |
| ho_data_i | input | 8 | Host OOB in byte |
| ho_last_i | input | 1 | Host OOB in last byte |
| ho_ready_o | output | 1 | Host OOB in ready |
| fo_valid_o | output | 1 | Raw out valid (write) |
| fo_data_o | output | 8 | Raw out byte |
| fo_last_o | output | 1 | Raw out final byte |
| fo_ready_i | input | 1 | Raw out ready |
| fi_valid_i | input | 1 | Raw in valid (read) |
| fi_data_i | input | 8 | Raw in byte |
| fi_last_i | input | 1 | Raw in last byte |
| fi_ready_o | output | 1 | Raw in ready |
| rd_valid_o | output | 1 | Host data out valid (read) |
| rd_data_o | output | 8 | Host data out byte |
| rd_last_o | output | 1 | Host data out final byte |
| rd_ready_i | input | 1 | Host data out ready |
| ro_valid_o | output | 1 | Host OOB out valid (read) |
| ro_data_o | output | 8 | Host OOB out byte |
| ro_last_o | output | 1 | Host OOB out final byte |
| ro_ready_i | input | 1 | Host OOB out ready |

## Verification
The bench builds the block with its default parameters: STEP_W = 11, NUM_W = 6, STRENGTH = 8. These values cover the real 512- and 1024-byte steps, which are checked once each at full length. Because step size is a run-time input, small steps (3 to 40 bytes) fill most of the run, so that many step boundaries, multi-step pages and early-end cases fit in a short run. The 3-byte step gives an odd raw parity count and so exercises rounding up to an even length, the 5-byte step gives an even count with no rounding, and the 512-byte step exercises the fixed 14-byte override.

// File: rtl/nfc_layout_pkg.sv
package nfc_layout_pkg;

  localparam int unsigned USER_BYTES = 2;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_USER = 2'd1,
    PH_PAR  = 2'd2
  } phase_e;

  // parity bytes per step: fixed 14 for 512B at strength 8, else
  // ceil(strength * bitlength(bits) / 8) rounded up to even
  function automatic logic [7:0] parity_len(input logic [31:0] step_bytes,
                                            input int unsigned strength);
    logic [31:0] bits;
    int unsigned bl;
    int unsigned n;
    bits = step_bytes << 3;
    bl   = 0;
    for (int b = 0; b < 32; b++) begin
      if (bits[b]) bl = b + 1;
    end
    n = (strength * bl + 7) / 8;
    if (n[0]) n = n + 1;
    if (step_bytes == 32'd512 && strength == 8) n = 14;
    return n[7:0];
  endfunction

endpackage

// File: rtl/nfc_layout_seq.sv
module nfc_layout_seq
  import nfc_layout_pkg::*;
#(
  parameter int unsigned STEP_W   = 11,
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned STRENGTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_mode_i,
  input  logic              oob_en_i,
  input  logic [STEP_W-1:0] step_bytes_i,
  input  logic [NUM_W-1:0]  step_num_i,
  input  logic              beat_i,
  input  logic              abort_i,
  output logic              active_o,
  output logic              rd_mode_o,
  output logic              oob_en_o,
  output phase_e            phase_o,
  output logic              data_end_o,
  output logic              page_end_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [STEP_W-1:0] USER_LAST = STEP_W'(USER_BYTES - 1);

  logic              active_q, mode_q, oob_q, done_q, err_q;
  logic [STEP_W-1:0] sb_q, cnt_q, par_last;
  logic [NUM_W-1:0]  num_q, step_q;
  logic [7:0]        par_q;
  phase_e            phase_q;
  logic              last_step, data_last, par_done;

  assign par_last   = STEP_W'(par_q) - 1'b1;
  assign last_step  = (step_q == num_q - 1'b1);
  assign data_last  = (cnt_q == sb_q - 1'b1);
  assign par_done   = (phase_q == PH_PAR) && (cnt_q == par_last);
  assign page_end_o = par_done && last_step;
  assign data_end_o = (phase_q == PH_DATA) && data_last && last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      oob_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      sb_q     <= '0;
      num_q    <= '0;
      par_q    <= '0;
      cnt_q    <= '0;
      step_q   <= '0;
      phase_q  <= PH_DATA;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!active_q) begin
        if (start_i && (|step_bytes_i) && (|step_num_i)) begin
          active_q <= 1'b1;
          mode_q   <= rd_mode_i;
          oob_q    <= oob_en_i;
          sb_q     <= step_bytes_i;
          num_q    <= step_num_i;
          par_q    <= parity_len(32'(step_bytes_i), STRENGTH);
          cnt_q    <= '0;
          step_q   <= '0;
          phase_q  <= PH_DATA;
        end
      end else if (abort_i) begin
        active_q <= 1'b0;
        err_q    <= 1'b1;
      end else if (beat_i) begin
        if (page_end_o) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          unique case (phase_q)
            PH_DATA: begin
              if (data_last) begin
                phase_q <= PH_USER;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            PH_USER: begin
              if (cnt_q == USER_LAST) begin
                phase_q <= PH_PAR;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            PH_PAR: begin
              if (par_done) begin
                phase_q <= PH_DATA;
                cnt_q   <= '0;
                step_q  <= step_q + 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: phase_q <= PH_DATA;
          endcase
        end
      end
    end
  end

  assign active_o  = active_q;
  assign rd_mode_o = mode_q;
  assign oob_en_o  = oob_q;
  assign phase_o   = phase_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/nfc_wr_merge.sv
module nfc_wr_merge
  import nfc_layout_pkg::*;
(
  input  logic       en_i,
  input  logic       oob_en_i,
  input  phase_e     phase_i,
  input  logic       page_end_i,
  input  logic       hd_valid_i,
  input  logic [7:0] hd_data_i,
  output logic       hd_ready_o,
  input  logic       ho_valid_i,
  input  logic [7:0] ho_data_i,
  output logic       ho_ready_o,
  output logic       fo_valid_o,
  output logic [7:0] fo_data_o,
  output logic       fo_last_o,
  input  logic       fo_ready_i,
  output logic       beat_o
);

  logic in_data;
  logic src_valid;

  assign in_data = (phase_i == PH_DATA);

  always_comb begin
    if (in_data) begin
      src_valid = hd_valid_i;
      fo_data_o = hd_data_i;
    end else if (oob_en_i) begin
      src_valid = ho_valid_i;
      fo_data_o = ho_data_i;
    end else begin
      src_valid = 1'b1;
      fo_data_o = 8'hFF;
    end
  end

  assign fo_valid_o = en_i && src_valid;
  assign fo_last_o  = en_i && page_end_i;
  assign hd_ready_o = en_i && in_data && fo_ready_i;
  assign ho_ready_o = en_i && !in_data && oob_en_i && fo_ready_i;
  assign beat_o     = fo_valid_o && fo_ready_i;

endmodule

// File: rtl/nfc_rd_split.sv
module nfc_rd_split
  import nfc_layout_pkg::*;
(
  input  logic       en_i,
  input  phase_e     phase_i,
  input  logic       data_end_i,
  input  logic       page_end_i,
  input  logic       fi_valid_i,
  input  logic [7:0] fi_data_i,
  output logic       fi_ready_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       rd_last_o,
  input  logic       rd_ready_i,
  output logic       ro_valid_o,
  output logic [7:0] ro_data_o,
  output logic       ro_last_o,
  input  logic       ro_ready_i,
  output logic       beat_o
);

  logic in_data;

  assign in_data    = (phase_i == PH_DATA);
  assign rd_valid_o = en_i && in_data && fi_valid_i;
  assign ro_valid_o = en_i && !in_data && fi_valid_i;
  assign rd_data_o  = fi_data_i;
  assign ro_data_o  = fi_data_i;
  assign rd_last_o  = en_i && data_end_i;
  assign ro_last_o  = en_i && page_end_i;
  assign fi_ready_o = en_i && (in_data ? rd_ready_i : ro_ready_i);
  assign beat_o     = fi_valid_i && fi_ready_o;

endmodule

// File: rtl/nfc_layout_interleave.sv
module nfc_layout_interleave
  import nfc_layout_pkg::*;
#(
  parameter int unsigned STEP_W   = 11,
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned STRENGTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_mode_i,
  input  logic              oob_en_i,
  input  logic [STEP_W-1:0] step_bytes_i,
  input  logic [NUM_W-1:0]  step_num_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic              hd_valid_i,
  input  logic [7:0]        hd_data_i,
  input  logic              hd_last_i,
  output logic              hd_ready_o,
  input  logic              ho_valid_i,
  input  logic [7:0]        ho_data_i,
  input  logic              ho_last_i,
  output logic              ho_ready_o,
  output logic              fo_valid_o,
  output logic [7:0]        fo_data_o,
  output logic              fo_last_o,
  input  logic              fo_ready_i,
  input  logic              fi_valid_i,
  input  logic [7:0]        fi_data_i,
  input  logic              fi_last_i,
  output logic              fi_ready_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i,
  output logic              ro_valid_o,
  output logic [7:0]        ro_data_o,
  output logic              ro_last_o,
  input  logic              ro_ready_i
);

  logic   active, mode_q, oob_q, data_end, page_end;
  logic   wr_en, rd_en, wr_beat, rd_beat, beat, abort;
  phase_e phase_q;

  nfc_layout_seq #(
    .STEP_W  (STEP_W),
    .NUM_W   (NUM_W),
    .STRENGTH(STRENGTH)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rd_mode_i   (rd_mode_i),
    .oob_en_i    (oob_en_i),
    .step_bytes_i(step_bytes_i),
    .step_num_i  (step_num_i),
    .beat_i      (beat),
    .abort_i     (abort),
    .active_o    (active),
    .rd_mode_o   (mode_q),
    .oob_en_o    (oob_q),
    .phase_o     (phase_q),
    .data_end_o  (data_end),
    .page_end_o  (page_end),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign wr_en = active && !mode_q;
  assign rd_en = active && mode_q;

  nfc_wr_merge u_wr (
    .en_i      (wr_en),
    .oob_en_i  (oob_q),
    .phase_i   (phase_q),
    .page_end_i(page_end),
    .hd_valid_i(hd_valid_i),
    .hd_data_i (hd_data_i),
    .hd_ready_o(hd_ready_o),
    .ho_valid_i(ho_valid_i),
    .ho_data_i (ho_data_i),
    .ho_ready_o(ho_ready_o),
    .fo_valid_o(fo_valid_o),
    .fo_data_o (fo_data_o),
    .fo_last_o (fo_last_o),
    .fo_ready_i(fo_ready_i),
    .beat_o    (wr_beat)
  );

  nfc_rd_split u_rd (
    .en_i      (rd_en),
    .phase_i   (phase_q),
    .data_end_i(data_end),
    .page_end_i(page_end),
    .fi_valid_i(fi_valid_i),
    .fi_data_i (fi_data_i),
    .fi_ready_o(fi_ready_o),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .rd_last_o (rd_last_o),
    .rd_ready_i(rd_ready_i),
    .ro_valid_o(ro_valid_o),
    .ro_data_o (ro_data_o),
    .ro_last_o (ro_last_o),
    .ro_ready_i(ro_ready_i),
    .beat_o    (rd_beat)
  );

  assign beat = rd_en ? rd_beat : wr_beat;

  // early end: a last flag accepted ahead of that stream's final byte
  always_comb begin
    abort = 1'b0;
    if (wr_en) begin
      if (hd_valid_i && hd_ready_o && hd_last_i && !data_end) abort = 1'b1;
      if (ho_valid_i && ho_ready_o && ho_last_i && !page_end) abort = 1'b1;
    end else if (rd_en) begin
      if (fi_valid_i && fi_ready_o && fi_last_i && !page_end) abort = 1'b1;
    end
  end

  assign busy_o = active;

endmodule

// File: rtl/nfc_layout_interleave_chk.sv
module nfc_layout_interleave_chk
  import nfc_layout_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       hd_ready_o,
  input logic       ho_ready_o,
  input logic       fo_valid_o,
  input logic [7:0] fo_data_o,
  input logic       fo_last_o,
  input logic       fo_ready_i,
  input logic       fi_ready_o,
  input logic       rd_valid_o,
  input logic       ro_valid_o,
  input logic       ro_last_o,
  input logic       ro_ready_i,
  input logic       mode_q,
  input logic       oob_q,
  input phase_e     phase_q
);

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R7

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o)); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past((fo_valid_o && fo_ready_i && fo_last_o) ||
                     (ro_valid_o && ro_ready_i && ro_last_o))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(fo_valid_o || rd_valid_o || ro_valid_o ||
                  hd_ready_o || ho_ready_o || fi_ready_o)); // R8

  AST_SPLIT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && ro_valid_o)); // R4

  AST_DIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fo_valid_o && (rd_valid_o || ro_valid_o))); // R8

  AST_FILL_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_q && !oob_q && phase_q != PH_DATA) |->
      (fo_valid_o && fo_data_o == 8'hFF && !ho_ready_o)); // R3

endmodule

bind nfc_layout_interleave nfc_layout_interleave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .hd_ready_o(hd_ready_o),
  .ho_ready_o(ho_ready_o),
  .fo_valid_o(fo_valid_o),
  .fo_data_o (fo_data_o),
  .fo_last_o (fo_last_o),
  .fo_ready_i(fo_ready_i),
  .fi_ready_o(fi_ready_o),
  .rd_valid_o(rd_valid_o),
  .ro_valid_o(ro_valid_o),
  .ro_last_o (ro_last_o),
  .ro_ready_i(ro_ready_i),
  .mode_q    (mode_q),
  .oob_q     (oob_q),
  .phase_q   (phase_q)
);

// File: tb/nfc_layout_interleave_test.sv
module nfc_layout_interleave_test;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_W     = 11;
  localparam int NUM_W      = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              start_i = 0, rd_mode_i = 0, oob_en_i = 0;
  logic [STEP_W-1:0] step_bytes_i = '0;
  logic [NUM_W-1:0]  step_num_i = '0;
  logic              busy_o, done_o, err_o;
  logic              hd_valid_i = 0, hd_last_i = 0, hd_ready_o;
  logic [7:0]        hd_data_i = '0;
  logic              ho_valid_i = 0, ho_last_i = 0, ho_ready_o;
  logic [7:0]        ho_data_i = '0;
  logic              fo_valid_o, fo_last_o, fo_ready_i = 0;
  logic [7:0]        fo_data_o;
  logic              fi_valid_i = 0, fi_last_i = 0, fi_ready_o;
  logic [7:0]        fi_data_i = '0;
  logic              rd_valid_o, rd_last_o, rd_ready_i = 0;
  logic [7:0]        rd_data_o;
  logic              ro_valid_o, ro_last_o, ro_ready_i = 0;
  logic [7:0]        ro_data_o;

  nfc_layout_interleave #(.STEP_W(STEP_W), .NUM_W(NUM_W), .STRENGTH(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rd_mode_i(rd_mode_i),
    .oob_en_i(oob_en_i), .step_bytes_i(step_bytes_i), .step_num_i(step_num_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .hd_valid_i(hd_valid_i), .hd_data_i(hd_data_i), .hd_last_i(hd_last_i), .hd_ready_o(hd_ready_o),
    .ho_valid_i(ho_valid_i), .ho_data_i(ho_data_i), .ho_last_i(ho_last_i), .ho_ready_o(ho_ready_o),
    .fo_valid_o(fo_valid_o), .fo_data_o(fo_data_o), .fo_last_o(fo_last_o), .fo_ready_i(fo_ready_i),
    .fi_valid_i(fi_valid_i), .fi_data_i(fi_data_i), .fi_last_i(fi_last_i), .fi_ready_o(fi_ready_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o), .rd_ready_i(rd_ready_i),
    .ro_valid_o(ro_valid_o), .ro_data_o(ro_data_o), .ro_last_o(ro_last_o), .ro_ready_i(ro_ready_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // R1 rule as stated
  function automatic int exp_par(input int sb);
    int bl = 0;
    int n;
    for (int b = 0; b < 32; b++) if (((sb * 8) >> b) & 1) bl = b + 1;
    n = (8 * bl + 7) / 8;
    if (n % 2) n++;
    if (sb == 512) n = 14;
    return n;
  endfunction

  task automatic idle_inputs();
    start_i = 0; hd_valid_i = 0; hd_last_i = 0; ho_valid_i = 0; ho_last_i = 0;
    fi_valid_i = 0; fi_last_i = 0; fo_ready_i = 0; rd_ready_i = 0; ro_ready_i = 0;
  endtask

  // cut: 0 none, 1 early host data last, 2 early host oob last, 3 early raw last
  task automatic run(input bit rd, input bit oen, input int sb, input int ns,
                     input int cut, input int cut_at, input bit mid_start, input string nm);
    int p, sec, hlen, olen, flen, hidx, oidx, fidx, cyc, lastbad, quietbad, oobbad;
    int mism, done_cnt;
    bit fin, err_seen, done_timed, final_fire;
    byte unsigned dq[$], oq[$], rq[$], gf[$], gd[$], go[$];
    p = exp_par(sb);
    sec = 2 + p;
    for (int i = 0; i < ns; i++) begin
      for (int j = 0; j < sb; j++) dq.push_back(8'($urandom));
      for (int j = 0; j < sec; j++) oq.push_back(8'($urandom));
    end
    for (int i = 0; i < ns; i++) begin
      for (int j = 0; j < sb; j++) rq.push_back(dq[i * sb + j]);
      for (int j = 0; j < sec; j++) rq.push_back((rd || oen) ? oq[i * sec + j] : 8'hFF);
    end
    hlen = dq.size(); olen = oq.size(); flen = rq.size();
    if (cut == 1) hlen = cut_at + 1;
    if (cut == 2) olen = cut_at + 1;
    if (cut == 3) flen = cut_at + 1;
    hidx = 0; oidx = 0; fidx = 0; cyc = 0; lastbad = 0; quietbad = 0; oobbad = 0;
    done_cnt = 0; fin = 0; err_seen = 0; done_timed = 0; final_fire = 0;

    @(negedge clk);
    rd_mode_i = rd; oob_en_i = oen;
    step_bytes_i = STEP_W'(sb); step_num_i = NUM_W'(ns); start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R9", {nm, " busy after start"}, int'(busy_o), 1);
    while (!fin && cyc < 40000) begin
      cyc++;
      if (mid_start && cyc == 3) begin
        start_i = 1; rd_mode_i = !rd; oob_en_i = !oen; step_bytes_i = 7; step_num_i = 1;
      end else start_i = 0;
      hd_valid_i = !rd && hidx < hlen && ($urandom % 4 != 0);
      hd_data_i  = (hidx < hlen) ? dq[hidx] : 8'h00;
      hd_last_i  = (hidx == hlen - 1);
      ho_valid_i = !rd && oen && oidx < olen && ($urandom % 4 != 0);
      ho_data_i  = (oidx < olen) ? oq[oidx] : 8'h00;
      ho_last_i  = (oidx == olen - 1);
      fi_valid_i = rd && fidx < flen && ($urandom % 4 != 0);
      fi_data_i  = (fidx < flen) ? rq[fidx] : 8'h00;
      fi_last_i  = (fidx == flen - 1);
      fo_ready_i = ($urandom % 3 != 0);
      rd_ready_i = ($urandom % 3 != 0);
      ro_ready_i = ($urandom % 3 != 0);
      #(CLK_PERIOD / 4);
      final_fire = 0;
      if (!rd && (rd_valid_o || ro_valid_o || fi_ready_o)) quietbad++;
      if (rd && (fo_valid_o || hd_ready_o || ho_ready_o)) quietbad++;
      if (!rd && !oen && ho_ready_o) oobbad++;
      if (hd_valid_i && hd_ready_o) hidx++;
      if (ho_valid_i && ho_ready_o) oidx++;
      if (fi_valid_i && fi_ready_o) fidx++;
      if (fo_valid_o && fo_ready_i) begin
        gf.push_back(fo_data_o);
        if (fo_last_o != (gf.size() == rq.size())) lastbad++;
        if (gf.size() == rq.size()) final_fire = 1;
      end
      if (rd_valid_o && rd_ready_i) begin
        gd.push_back(rd_data_o);
        if (rd_last_o != (gd.size() == dq.size())) lastbad++;
      end
      if (ro_valid_o && ro_ready_i) begin
        go.push_back(ro_data_o);
        if (ro_last_o != (go.size() == oq.size())) lastbad++;
        if (go.size() == oq.size()) final_fire = 1;
      end
      @(negedge clk);
      if (done_o) begin
        done_cnt++;
        done_timed = final_fire && !busy_o;
        fin = 1;
      end
      if (err_o) begin
        err_seen = 1;
        fin = 1;
      end
    end
    idle_inputs();
    @(negedge clk);
    if (cut == 0) begin
      chk(done_o == 1'b0 && busy_o == 1'b0, "R6", {nm, " done one cycle"}, int'(done_o), 0);
      if (!rd)
        chk(gf.size() == ns * (sb + sec), "R1", {nm, " raw length"}, gf.size(), ns * (sb + sec));
      else
        chk(go.size() == ns * sec, "R1", {nm, " oob length"}, go.size(), ns * sec);
      mism = 0;
      if (!rd) begin
        for (int k = 0; k < gf.size() && k < rq.size(); k++) if (gf[k] != rq[k]) mism++;
        chk(mism == 0, oen ? "R2" : "R3", {nm, " raw bytes mismatched"}, mism, 0);
      end else begin
        for (int k = 0; k < gd.size() && k < dq.size(); k++) if (gd[k] != dq[k]) mism++;
        for (int k = 0; k < go.size() && k < oq.size(); k++) if (go[k] != oq[k]) mism++;
        chk(mism == 0 && gd.size() == dq.size(), "R4", {nm, " split bytes mismatched"}, mism, 0);
      end
      if (!rd && !oen) chk(oobbad == 0, "R3", {nm, " oob ready raised"}, oobbad, 0);
      chk(lastbad == 0, "R5", {nm, " last flag errors"}, lastbad, 0);
      chk(done_cnt == 1 && done_timed && !err_seen, "R6", {nm, " done timing"}, done_cnt, 1);
      chk(quietbad == 0, "R8", {nm, " unused direction active"}, quietbad, 0);
      if (mid_start) chk(mism == 0 && done_cnt == 1, "R9", {nm, " restart ignored"}, mism, 0);
    end else begin
      chk(err_seen && done_cnt == 0, "R7", {nm, " early end error"}, int'(err_seen), 1);
      chk(busy_o == 1'b0 && err_o == 1'b0, "R7", {nm, " idle after error"}, int'(busy_o), 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
    fails++;
    checks++;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy_o && !done_o && !err_o, "R10", "status after reset", int'(busy_o), 0);
    chk(!fo_valid_o && !rd_valid_o && !ro_valid_o && !hd_ready_o && !ho_ready_o && !fi_ready_o,
        "R10", "handshake outputs after reset", int'(fo_valid_o), 0);
    chk(exp_par(512) == 14 && exp_par(1024) == 14 && exp_par(3) == 6, "R1", "parity rule",
        exp_par(3), 6);

    run(0, 1, 16, 4, 0, 0, 0, "wr oob 16x4");
    run(0, 1, 3, 2, 0, 0, 0, "wr oob 3x2 odd");
    run(0, 0, 8, 3, 0, 0, 0, "wr fill 8x3");
    run(1, 1, 16, 3, 0, 0, 0, "rd 16x3");
    run(1, 0, 5, 2, 0, 0, 0, "rd 5x2");
    run(0, 1, 512, 1, 0, 0, 0, "wr 512x1");
    run(1, 1, 1024, 2, 0, 0, 0, "rd 1024x2");
    run(0, 1, 100, 2, 0, 0, 1, "wr restart 100x2");
    run(0, 1, 16, 2, 1, 20, 0, "wr data early");
    run(0, 1, 16, 2, 2, 3, 0, "wr oob early");
    run(1, 1, 8, 2, 3, 10, 0, "rd raw early");
    run(0, 0, 24, 2, 0, 0, 0, "wr after error");
    for (int t = 0; t < 6; t++) begin
      run(bit'($urandom % 2), bit'($urandom % 2), 1 + int'($urandom % 40),
          1 + int'($urandom % 4), 0, 0, 0, "random");
    end
    summary();
    $finish;
  end

endmodule